// File: doc/BRIEF.md
# Staged-Reload Clock Divider

The block takes a parent clock and gives out one divided clock. The divide ratio can be changed while the block runs. The output is gated by an enable bit. Software reaches the block through a small register bus with two 32-bit words: a control word at byte offset 0 and a ratio word at byte offset 8.

A new ratio is not applied when it is written. Software first places the value in a staging field of the ratio word. It then sets the channel's force flag in the control word, and then raises the global reload bit. The staged value, clamped to the nearest supported ratio (4, 5, 6 or 8), is captured when the force flag and the reload bit first become set together. The divider switches to the captured value at its next period boundary, while the output is low. Software may clear the flags afterwards, and doing so has no effect on the running ratio.

The enable bit is also applied only at a period boundary. As a result the output only ever carries whole pulses. The divider counter keeps counting while the output is gated.

Top module: `clkdiv_reload`

## Requirements
- R1: After reset the control word (offset 0) reads 0x00000000. The ratio word (offset 8) reads 0x00000400, which is a staged value of 4. The output is low, and the active ratio is 4.
- R2: The output enable is control bit 25. While it is clear, the output stays low.
- R3: The staged ratio is the 6-bit field at bits 13:8 of the ratio word (offset 8). The field reads back exactly as written. All other bits of the ratio word read 0, and the control word reads back as written.
- R4: Writing only the staged ratio field leaves the output period unchanged.
- R5: The staged value is captured only when the channel force flag (control bit 1) and the reload bit (control bit 8) become set together. Either flag alone has no effect. The force flag of another channel (bit 0) with reload also has no effect.
- R6: With active ratio N, the output repeats every N parent cycles and is high for floor(N/2) of them.
- R7: A staged value below 4 is applied as 4. A staged value above 6 is applied as 8. The values 4, 5 and 6 are applied as written.
- R8: Clearing the force flag and the reload bit after a reload leaves the active ratio unchanged.
- R9: A new ratio takes effect only at a period boundary while the output is low. Each period around the switch has the old length or the new length, never a runt.
- R10: A change of the enable bit takes effect only at a period boundary, so a pulse already in progress completes at full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Byte offset of the register word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| clk_out | output | 1 | Gated divided clock, registered |

## Verification
The embedded assertions check several properties on every cycle:
- the active ratio is always one of the four legal values;
- the active ratio changes only at a boundary with the output low;
- the active ratio stays put when no reload is pending;
- a gated period produces no high output.

The bench shows the remaining behaviour through scenarios:
- it sweeps all 64 staged values to show the clamping, the readback and the period and high-time arithmetic;
- it shows that stray flag combinations and bare staging writes are ignored;
- it checks that pulses stay whole across a ratio switch and when the enable is cleared mid-pulse.

// File: rtl/clkdiv_reload.sv
module clkdiv_reload #(
  parameter int CH          = 1,
  parameter int EN_BASE     = 24,
  parameter int RELOAD_BIT  = 8,
  parameter int RATIO_LSB   = 8,
  parameter int RATIO_W     = 6,
  parameter int RESET_RATIO = 4,
  parameter int ADDR_W      = 4,
  parameter int CNT_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              clk_out
);
  localparam logic [ADDR_W-1:0] CTRL_OFS  = '0;
  localparam logic [ADDR_W-1:0] RATIO_OFS = ADDR_W'(8);
  localparam int                EN_BIT    = EN_BASE + CH;

  function automatic logic [CNT_W-1:0] legalize(input logic [RATIO_W-1:0] v);
    if (v < RATIO_W'(4))      return CNT_W'(4);
    else if (v > RATIO_W'(6)) return CNT_W'(8);
    else                      return CNT_W'(v);
  endfunction

  logic [31:0]        ctrl;
  logic [RATIO_W-1:0] staged;
  logic [CNT_W-1:0]   act, pend_val, cnt;
  logic               pend, trig_q, gate;

  wire              trig   = ctrl[RELOAD_BIT] & ctrl[CH];
  wire              wrap   = (cnt == act - CNT_W'(1));
  wire [CNT_W-1:0]  cnt_n  = wrap ? '0 : cnt + CNT_W'(1);
  wire [CNT_W-1:0]  act_n  = (wrap && pend) ? pend_val : act;
  wire              gate_n = wrap ? ctrl[EN_BIT] : gate;

  always_comb begin
    rdata = '0;
    if (addr == CTRL_OFS)       rdata = ctrl;
    else if (addr == RATIO_OFS) rdata[RATIO_LSB +: RATIO_W] = staged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      staged <= RATIO_W'(RESET_RATIO);
    end else if (wr_en) begin
      if (addr == CTRL_OFS)  ctrl   <= wdata;
      if (addr == RATIO_OFS) staged <= wdata[RATIO_LSB +: RATIO_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q   <= 1'b0;
      pend     <= 1'b0;
      pend_val <= CNT_W'(RESET_RATIO);
    end else begin
      trig_q <= trig;
      if (trig && !trig_q) begin
        pend     <= 1'b1;
        pend_val <= legalize(staged);
      end else if (wrap) begin
        pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      act     <= CNT_W'(RESET_RATIO);
      gate    <= 1'b0;
      clk_out <= 1'b0;
    end else begin
      cnt     <= cnt_n;
      act     <= act_n;
      gate    <= gate_n;
      clk_out <= gate_n & (cnt_n < (act_n >> 1));
    end
  end

  always_comb
    p_ratio_legal_r7: assert (!rst_n || act == 4 || act == 5 || act == 6 || act == 8);

  p_switch_on_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(act));
  p_low_at_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> !clk_out);
  p_idle_keeps_ratio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> $stable(act));
  p_gated_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !ctrl[EN_BIT]) |=> !clk_out);
  p_gate_on_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(gate));
endmodule

// File: tb/clkdiv_reload_test.sv
module clkdiv_reload_test;
  logic        clk = 0, rst_n = 0, wr_en = 0, clk_out;
  logic [3:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  int checks = 0, errors = 0;

  localparam logic [31:0] EN = 32'h0200_0000, FRC = 32'h2, RLD = 32'h100;

  clkdiv_reload uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                     .wdata(wdata), .rdata(rdata), .clk_out(clk_out));

  always #5 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic int expect_ratio(int v);
    if (v < 4) return 4;
    if (v > 6) return 8;
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; addr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic measure(output int per, output int hi);
    int lo;
    do @(negedge clk); while (clk_out !== 1'b0);
    do @(negedge clk); while (clk_out !== 1'b1);
    hi = 0; lo = 0;
    while (clk_out === 1'b1) begin hi++; @(negedge clk); end
    while (clk_out === 1'b0) begin lo++; @(negedge clk); end
    per = hi + lo;
  endtask

  task automatic reload(int v);
    wr(4'd8, 32'(v) << 8);
    wr(4'd0, EN | FRC);
    wr(4'd0, EN | FRC | RLD);
    wr(4'd0, EN);
  endtask

  initial begin
    logic [31:0] d;
    int per, hi, cur, lowcnt;
    repeat (3) @(negedge clk);
    rd(4'd0, d); check("R1 ctrl reset", d, 0);
    rd(4'd8, d); check("R1 ratio reset", d, 32'h400);
    check("R1 out low", clk_out, 0);
    rst_n = 1;
    repeat (10) @(negedge clk);
    check("R2 out low while disabled", clk_out, 0);
    wr(4'd0, EN);
    measure(per, hi); check("R1 reset ratio", per, 4); check("R6 reset high", hi, 2);
    rd(4'd0, d); check("R3 ctrl readback", d, EN);
    cur = 4;

    for (int v = 0; v < 64; v++) begin
      reload(v);
      rd(4'd8, d); check("R3 staged readback", d, v << 8);
      measure(per, hi); measure(per, hi);
      check("R7 period", per, expect_ratio(v));
      check("R6 high time", hi, expect_ratio(v) / 2);
      check("R8 ratio kept after clear", per, expect_ratio(v));
      cur = expect_ratio(v);
    end

    reload(5); cur = 5;
    wr(4'd8, 32'h0000_0800);
    measure(per, hi); measure(per, hi); check("R4 staging only", per, cur);
    wr(4'd0, EN | FRC); wr(4'd0, EN);
    measure(per, hi); measure(per, hi); check("R5 force only", per, cur);
    wr(4'd0, EN | RLD); wr(4'd0, EN);
    measure(per, hi); measure(per, hi); check("R5 reload only", per, cur);
    wr(4'd0, EN | 32'h1); wr(4'd0, EN | 32'h1 | RLD); wr(4'd0, EN);
    measure(per, hi); measure(per, hi); check("R5 other channel", per, cur);

    reload(8);
    for (int k = 0; k < 4; k++) begin
      measure(per, hi);
      checks++;
      if (!((per == 5 && hi == 2) || (per == 8 && hi == 4))) begin
        errors++;
        $display("FAIL R9 switch: actual per %0d hi %0d expected 5/2 or 8/4", per, hi);
      end
    end
    check("R9 settled", per, 8);

    do @(negedge clk); while (clk_out !== 1'b0);
    do @(negedge clk); while (clk_out !== 1'b1);
    wr_en = 1; addr = 0; wdata = 32'h0; hi = 1;
    @(negedge clk); wr_en = 0;
    while (clk_out === 1'b1) begin hi++; @(negedge clk); end
    check("R10 full pulse on disable", hi, 4);
    lowcnt = 0;
    repeat (40) begin @(negedge clk); if (clk_out === 1'b0) lowcnt++; end
    check("R2 gated low", lowcnt, 40);
    wr(4'd0, EN);
    measure(per, hi); check("R10 whole pulse on enable", hi, 4); check("R6 after enable", per, 8);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule